// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flags and Request

This block gathers the three interrupt causes of a real-time clock (alarm match, periodic rate, end of time update) and turns them into one active-low request line. Each cause has an enable bit and a status flag. Both sit behind a small byte-wide register interface with a one-bit register select. The alarm and update-ended causes come in as single-cycle pulses from the clock's counting logic. The periodic cause is made internally by dividing a 32.768 kHz tick by a power of two chosen with a 4-bit rate select.

A flag records its event whether or not the matching enable is set, so software can poll a flag without taking interrupts. Reading the status register clears the flags that the read returned. While the read strobe is high the flags are frozen, so the value on the bus cannot change under the host. Events that arrive during that time are parked and then merged into the flags on the clock where the strobe is seen low.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset all enables and flags are 0, `irq_n` is 1, and both registers read 0x00.
- R2: With `reg_sel`=0 a write strobe loads the enable register. Bit 6 enables periodic, bit 5 enables alarm and bit 4 enables update-ended. Reading with `reg_sel`=0 returns those three bits in place, and every other bit reads 0.
- R3: A pulse on a source sets its flag on the next clock edge whatever its enable is. The status register (`reg_sel`=1) shows the periodic flag in bit 6, the alarm flag in bit 5 and the update-ended flag in bit 4. Bits 3 to 0 read 0.
- R4: `irq_n` is 0 exactly when some flag and its enable are both 1. Status bit 7 reads 1 under the same condition.
- R5: Setting the enable of a flag that is already set drives `irq_n` low in the first cycle after the write edge.
- R6: While `rd_strobe` is high with `reg_sel`=1, the status value does not change. On the clock where the strobe is first seen low, every flag that was read is cleared.
- R7: A source pulse that arrives while a status read is in progress, or in the cycle that ends the read, is not lost. It sets its flag when the read ends.
- R8: With the rate select `s` from 3 to 15, the periodic flag is set once every 2^(s-1) ticks. Select 1 gives 128 ticks and select 2 gives 256 ticks.
- R9: A rate select of 0 never sets the periodic flag.
- R10: A write strobe with `reg_sel`=1 has no effect: the flags and the enables are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz period |
| rate_sel | input | SEL_W | Periodic rate select, 0 turns the periodic source off |
| reg_sel | input | 1 | Register select: 0 enables, 1 status |
| wr_strobe | input | 1 | Write strobe |
| rd_strobe | input | 1 | Read strobe; for status, its falling edge clears the flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | Update-ended pulse |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
All eight enable patterns are crossed with all four alarm/update event patterns. This separates setting a flag from gating the request, and it catches swapped bit positions. Every rate select from 0 to 15 is run with a tick on every cycle, and the spacing between two successive request edges is measured. This tells the tap decode and the aliasing of selects 1 and 2 apart from an off-by-one in the divider. Directed reads inject events in the middle of the read and in the cycle that ends it. These show the difference between freezing, deferring and dropping an event, and they also check the one-cycle response to a late enable.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int REG_W   = 8;
    localparam int SRC_N   = 3;
    localparam int EN_LSB  = 4;
    localparam int IRQ_BIT = 7;

    localparam int IDX_UPD = 0;
    localparam int IDX_ALM = 1;
    localparam int IDX_PER = 2;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } src_t;

    // Divider mask for a rate select: period is mask+1 ticks; 0 means off.
    function automatic int unsigned rate_mask(input int unsigned sel);
        int unsigned tap;
        case (sel)
            0:       tap = 0;
            1:       tap = 8;
            2:       tap = 9;
            default: tap = sel;
        endcase
        if (tap == 0) return 0;
        return (32'd1 << (tap - 1)) - 32'd1;
    endfunction

endpackage

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen #(
    parameter int SEL_W = 4,
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] mask;

    always_comb mask = DIV_W'(rtc_irq_pkg::rate_mask(32'(sel)));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    assign pulse = tick && (sel != '0) && ((cnt & mask) == mask);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] evt,
    input  logic             rd_act,
    output logic [SRC_N-1:0] flags
);
    logic rd_q;
    logic rd_done;

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= rd_act;
    end

    assign rd_done = rd_q && !rd_act;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        logic held;
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
                held     <= 1'b0;
            end else if (rd_act) begin
                held     <= held | evt[i];
            end else if (rd_done) begin
                flags[i] <= held | evt[i];
                held     <= 1'b0;
            end else begin
                flags[i] <= flags[i] | evt[i];
            end
        end
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_32k,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             reg_sel,
    input  logic             wr_strobe,
    input  logic             rd_strobe,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             alarm_evt,
    input  logic             update_evt,
    output logic             irq_n
);
    src_t             evt;
    logic             per_pulse;
    logic [SRC_N-1:0] flags;
    logic [SRC_N-1:0] en;
    logic             is_status;
    logic             c_rd;
    logic             any_irq;

    rtc_rate_gen #(.SEL_W(SEL_W), .DIV_W(DIV_W)) i_rate (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_32k),
        .sel   (rate_sel),
        .pulse (per_pulse)
    );

    always_comb begin
        evt.per = per_pulse;
        evt.alm = alarm_evt;
        evt.upd = update_evt;
    end

    assign is_status = (reg_sel_e'(reg_sel) == SEL_STATUS);
    assign c_rd      = rd_strobe && is_status;

    rtc_flag_bank i_flags (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .rd_act (c_rd),
        .flags  (flags)
    );

    always_ff @(posedge clk) begin
        if (rst)                          en <= '0;
        else if (wr_strobe && !is_status) en <= wdata[EN_LSB +: SRC_N];
    end

    assign any_irq = |(flags & en);
    assign irq_n   = !any_irq;

    always_comb begin
        rdata = '0;
        if (is_status) begin
            rdata[IRQ_BIT]            = any_irq;
            rdata[EN_LSB +: SRC_N]    = flags;
        end else begin
            rdata[EN_LSB +: SRC_N]    = en;
        end
    end
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk
    import rtc_irq_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] rate_sel,
    input logic             reg_sel,
    input logic             wr_strobe,
    input logic             rd_strobe,
    input logic [SRC_N-1:0] wr_en_bits,
    input logic [REG_W-1:0] rdata,
    input logic             irq_n,
    input logic [SRC_N-1:0] flags,
    input logic [SRC_N-1:0] en,
    input logic [SRC_N-1:0] evt,
    input logic             per_pulse
);
    logic             c_rd;
    logic             prev_crd;
    logic             prev_wr;
    logic [SRC_N-1:0] seen;

    assign c_rd = rd_strobe && reg_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_crd <= 1'b0;
            prev_wr  <= 1'b0;
            seen     <= '0;
        end else begin
            prev_crd <= c_rd;
            prev_wr  <= wr_strobe;
            seen     <= c_rd ? (seen | evt) : '0;
        end
    end

    assert_evt_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (!c_rd && evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    assert_irq_follows_state_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> (flags != $past(flags) || en != $past(en)));

    assert_late_enable_fires_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && !reg_sel && !c_rd && !prev_crd && (wr_en_bits & flags) != '0)
        |=> !irq_n);

    assert_read_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (c_rd && prev_crd && !prev_wr) |-> $stable(rdata));

    assert_deferred_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (prev_crd && !c_rd) |=> (flags == ($past(seen) | $past(evt))));

    assert_periodic_off_R9: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == '0) |-> !per_pulse);

    assert_status_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && reg_sel) |=> $stable(en));
endmodule

bind rtc_irq_ctrl rtc_irq_chk #(.SEL_W(SEL_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .reg_sel    (reg_sel),
    .wr_strobe  (wr_strobe),
    .rd_strobe  (rd_strobe),
    .wr_en_bits (wdata[6:4]),
    .rdata      (rdata),
    .irq_n      (irq_n),
    .flags      (flags),
    .en         (en),
    .evt        (evt),
    .per_pulse  (per_pulse)
);

// File: tb/test_rtc_irq_ctrl.sv
module test_rtc_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       reg_sel = 1'b0;
    logic       wr_strobe = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       alarm_evt = 1'b0;
    logic       update_evt = 1'b0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    localparam int WATCHDOG = 190000;

    rtc_irq_ctrl i_rtc_irq_ctrl (
        .clk(clk), .rst(rst), .tick_32k(tick_32k), .rate_sel(rate_sel),
        .reg_sel(reg_sel), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
        .wdata(wdata), .rdata(rdata), .alarm_evt(alarm_evt),
        .update_evt(update_evt), .irq_n(irq_n)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        reg_sel = sel; wdata = d; wr_strobe = 1'b1;
        step();
        wr_strobe = 1'b0;
    endtask

    task automatic read_status();
        reg_sel = 1'b1; rd_strobe = 1'b1;
        step();
        rd_strobe = 1'b0;
        step();
    endtask

    task automatic pulse(input logic a, input logic u);
        alarm_evt = a; update_evt = u;
        step();
        alarm_evt = 1'b0; update_evt = 1'b0;
    endtask

    task automatic wait_low(input int limit, output int t);
        t = -1;
        for (int k = 0; k < limit; k++) begin
            if (!irq_n) begin
                t = cyc;
                return;
            end
            step();
        end
    endtask

    function automatic int exp_period(input int s);
        if (s == 1) return 128;
        if (s == 2) return 256;
        return 1 << (s - 1);
    endfunction

    initial begin
        int ta, t1, t2;
        bit stayed;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1: reset state
        check("R1 irq_n after reset", irq_n, 1);
        reg_sel = 1'b0; #1;
        check("R1 enable reg after reset", rdata, 8'h00);
        reg_sel = 1'b1; #1;
        check("R1 status reg after reset", rdata, 8'h00);

        // R2: enable readback, all patterns, junk in other bits
        for (int e = 0; e < 8; e++) begin
            write_reg(1'b0, {1'b1, e[2:0], 4'hF});
            reg_sel = 1'b0; #1;
            check("R2 enable readback", rdata, {1'b0, e[2:0], 4'h0});
        end

        // R3 / R4: enables x alarm/update events
        for (int e = 0; e < 8; e++) begin
            for (int s = 0; s < 4; s++) begin
                logic a, u, any;
                a = s[1]; u = s[0];
                any = (a & e[1]) | (u & e[0]);
                write_reg(1'b0, {1'b0, e[2:0], 4'h0});
                read_status();
                pulse(a, u);
                reg_sel = 1'b1; #1;
                check("R3 R4 status after events", rdata, {any, 1'b0, a, u, 4'h0});
                check("R4 irq_n gating", irq_n, !any);
            end
        end

        // R5: late enable of an already-set flag
        write_reg(1'b0, 8'h00);
        read_status();
        pulse(1'b1, 1'b0);
        check("R5 irq_n before enable", irq_n, 1);
        write_reg(1'b0, 8'h20);
        check("R5 irq_n one cycle after enable", irq_n, 0);

        // R6 / R7: frozen read, deferred events
        write_reg(1'b0, 8'h70);
        read_status();
        pulse(1'b1, 1'b0);
        reg_sel = 1'b1; rd_strobe = 1'b1;
        step();
        check("R6 value at read start", rdata, 8'hA0);
        update_evt = 1'b1;
        step();
        update_evt = 1'b0;
        check("R6 value stable with event mid-read", rdata, 8'hA0);
        step();
        check("R6 value stable later in read", rdata, 8'hA0);
        rd_strobe = 1'b0;
        step();
        check("R7 deferred update applied after read", rdata, 8'h90);
        check("R7 irq_n for deferred update", irq_n, 0);
        rd_strobe = 1'b1;
        step();
        rd_strobe = 1'b0; alarm_evt = 1'b1;
        step();
        alarm_evt = 1'b0;
        check("R7 event in read-ending cycle kept", rdata, 8'hA0);
        read_status();
        check("R6 read clears flags", rdata, 8'h00);
        check("R6 irq_n released after clear", irq_n, 1);

        // R10: status write ignored
        pulse(1'b1, 1'b0);
        write_reg(1'b1, 8'h00);
        reg_sel = 1'b1; #1;
        check("R10 status unchanged by write", rdata, 8'hA0);
        reg_sel = 1'b0; #1;
        check("R10 enables unchanged by status write", rdata, 8'h70);

        // R8: periodic rate sweep, tick every cycle
        write_reg(1'b0, 8'h40);
        read_status();
        tick_32k = 1'b1;
        for (int s = 1; s < 16; s++) begin
            int p;
            p = exp_period(s);
            rate_sel = 4'(s);
            read_status();
            wait_low(2 * p + 8, ta);
            read_status();
            wait_low(2 * p + 8, t1);
            reg_sel = 1'b1; #1;
            check($sformatf("R8 status on periodic sel %0d", s), rdata, 8'hC0);
            read_status();
            wait_low(2 * p + 8, t2);
            check($sformatf("R8 period sel %0d", s), (t1 < 0 || t2 < 0) ? -1 : t2 - t1, p);
        end

        // R9: select 0 is off
        rate_sel = 4'd0;
        read_status();
        stayed = 1'b1;
        for (int k = 0; k < 300; k++) begin
            if (!irq_n) stayed = 1'b0;
            step();
        end
        check("R9 no request with select 0", stayed, 1);
        reg_sel = 1'b1; #1;
        check("R9 no periodic flag with select 0", rdata, 8'h00);
        tick_32k = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule